// File: doc/BRIEF.md
# Two-Stage Timebase Watchdog

This peripheral guards a system against a stalled processor. It sits on a simple 32-bit register bus with single-cycle read and write strobes and a word address. Software turns it on by setting two enable bits that live in two separate registers. From then on an interval counter of width N wraps every 2^N clock cycles.

The first wrap does not reset anything. It raises a state flag and pulses an interrupt, so software gets a warning. Software services the watchdog by writing 1 to the state flag. That clears the flag and restarts the interval from zero. If the counter wraps a second time while the flag is still set, the block drives a stretched system-reset pulse and latches a reset-cause flag. The cause flag survives that reset, so boot code can find out why the system restarted.

A free-running timebase register increments on every clock. Software can read it twice to confirm that the block is clocked. A build-time option locks the first enable bit once it has been set.

Top module: `wdog_twostage`

## Requirements
- R1: Word 0 holds the control/status bits: bit 3 is the reset-cause flag, bit 2 is the state flag and bit 1 is enable A. Word 1 bit 0 is enable B. Word 2 is the timebase. Read data appears on `bus_rdata` one cycle after the read strobe. Every unused bit and word reads 0, including word 3.
- R2: The interval counter advances only while enable A and enable B are both 1. With either enable at 0, no interrupt and no reset ever occur.
- R3: Exactly 2^N cycles after the edge that completes the enable, the first expiry sets the state flag and drives `wdt_irq` high for exactly one cycle.
- R4: If the counter wraps again while the state flag is set (2^(N+1) cycles after enabling with no service), `wdt_reset` goes high for RST_LEN cycles and the reset-cause flag is set.
- R5: Writing word 0 with bit 2 set clears the state flag and restarts the interval from zero. The next expiry then comes 2^N cycles after that write, and no reset occurs while service continues.
- R6: The reset-cause flag stays set after the reset pulse ends. Only a write of 1 to word 0 bit 3, or the power-on reset `rst_n`, clears it.
- R7: The timebase increments by exactly 1 every clock, and writes to word 2 have no effect on it.
- R8: With ENABLE_ONCE set, a write of 0 to enable A after it has been set leaves enable A at 1.
- R9: Writing 0 to a flag bit in word 0 leaves that flag unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_addr | input | 2 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| wdt_irq | output | 1 | One-cycle interrupt on the first expiry |
| wdt_reset | output | 1 | Stretched system-reset pulse on the second expiry |

## Verification
The assertions assume the following about the bus:
- Write and read strobes are never X after reset.
- The address and write data are valid in every cycle where a strobe is high.
- `rst_n` is the only path that clears the block other than register writes.

The stimulus follows these rules:
- It drives every access for exactly one cycle, away from the clock edge.
- It never stacks two writes on the same register in one cycle.
- It always disables the timer before an unplanned third expiry could occur. This keeps every interrupt and reset pulse that appears tied to a scheduled expiry.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam logic [1:0] A_CTL0  = 2'd0;
  localparam logic [1:0] A_CTL1  = 2'd1;
  localparam logic [1:0] A_TBASE = 2'd2;

  localparam int B_CAUSE = 3;
  localparam int B_STATE = 2;
  localparam int B_ENA   = 1;
  localparam int B_ENB   = 0;

  typedef struct packed {
    logic cause;
    logic state;
    logic ena;
    logic enb;
  } ctl_t;
endpackage

// File: rtl/wdog_timebase.sv
module wdog_timebase #(
  parameter int TB_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [TB_W-1:0] tb_o
);
  logic [TB_W-1:0] tb_q, tb_n;

  always_comb tb_n = tb_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tb_q <= '0;
    else        tb_q <= tb_n;
  end

  assign tb_o = tb_q;
endmodule

// File: rtl/wdog_expiry.sv
module wdog_expiry #(
  parameter int CNT_W   = 16,
  parameter int RST_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic reload_i,
  input  logic state_i,
  output logic first_o,
  output logic second_o,
  output logic irq_o,
  output logic sysrst_o
);
  localparam int RCW = $clog2(RST_LEN + 1);

  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [RCW-1:0]   rcnt_q, rcnt_n;
  logic             irq_q, irq_n;
  logic             wrap;

  always_comb begin
    wrap     = run_i && !reload_i && (&cnt_q);
    first_o  = wrap && !state_i;
    second_o = wrap && state_i;

    cnt_n = cnt_q;
    if (reload_i)   cnt_n = '0;
    else if (run_i) cnt_n = cnt_q + 1'b1;

    irq_n = first_o;

    rcnt_n = rcnt_q;
    if (second_o)           rcnt_n = RCW'(RST_LEN);
    else if (rcnt_q != '0)  rcnt_n = rcnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      rcnt_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_n;
      rcnt_q <= rcnt_n;
      irq_q  <= irq_n;
    end
  end

  assign irq_o    = irq_q;
  assign sysrst_o = (rcnt_q != '0);

  // R3: the interrupt never lasts more than one cycle
  assert_irq_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o);

  // R2: a stopped timer cannot raise the interrupt
  assert_stop_no_irq_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> !irq_o);
endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int TB_W        = 32,
  parameter int ENABLE_ONCE = 0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_i,
  input  logic            rd_i,
  input  logic [1:0]      addr_i,
  input  logic [31:0]     wdata_i,
  input  logic [TB_W-1:0] tb_i,
  input  logic            first_i,
  input  logic            second_i,
  output ctl_t            ctl_o,
  output logic            kick_o,
  output logic [31:0]     rdata_o
);
  ctl_t        ctl_q, ctl_n;
  logic [31:0] rdata_q, rdata_n, mux;
  logic        wr0, wr1, lock_a;
  logic        unused_wbits;

  assign unused_wbits = ^wdata_i[31:4];

  always_comb begin
    wr0    = wr_i && (addr_i == A_CTL0);
    wr1    = wr_i && (addr_i == A_CTL1);
    lock_a = (ENABLE_ONCE != 0) && ctl_q.ena;
    kick_o = wr0 && wdata_i[B_STATE];

    ctl_n = ctl_q;
    if (wr0) begin
      if (!lock_a)            ctl_n.ena   = wdata_i[B_ENA];
      if (wdata_i[B_STATE])   ctl_n.state = 1'b0;
      if (wdata_i[B_CAUSE])   ctl_n.cause = 1'b0;
    end
    if (wr1)      ctl_n.enb   = wdata_i[B_ENB];
    if (first_i)  ctl_n.state = 1'b1;
    if (second_i) ctl_n.cause = 1'b1;

    mux = '0;
    case (addr_i)
      A_CTL0:  mux = {28'd0, ctl_q.cause, ctl_q.state, ctl_q.ena, 1'b0};
      A_CTL1:  mux = {31'd0, ctl_q.enb};
      A_TBASE: mux = 32'(tb_i);
      default: mux = '0;
    endcase

    rdata_n = rd_i ? mux : rdata_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q   <= '0;
      rdata_q <= '0;
    end else begin
      ctl_q   <= ctl_n;
      rdata_q <= rdata_n;
    end
  end

  assign ctl_o   = ctl_q;
  assign rdata_o = rdata_q;

  generate
    if (ENABLE_ONCE != 0) begin : g_once
      // R8: once set, enable A stays set
      assert_once_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.ena |=> ctl_q.ena);
    end
  endgenerate
endmodule

// File: rtl/wdog_twostage.sv
module wdog_twostage
  import wdog_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int RST_LEN     = 4,
  parameter int TB_W        = 32,
  parameter int ENABLE_ONCE = 0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [1:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        wdt_irq,
  output logic        wdt_reset
);
  ctl_t            ctl;
  logic            kick, run, reload, first, second;
  logic [TB_W-1:0] tb;

  assign run    = ctl.ena && ctl.enb;
  assign reload = kick || !run;

  wdog_timebase #(.TB_W(TB_W)) u_tb (
    .clk(clk), .rst_n(rst_n), .tb_o(tb)
  );

  wdog_regs #(.TB_W(TB_W), .ENABLE_ONCE(ENABLE_ONCE)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_i(bus_wr), .rd_i(bus_rd),
    .addr_i(bus_addr), .wdata_i(bus_wdata), .tb_i(tb),
    .first_i(first), .second_i(second), .ctl_o(ctl),
    .kick_o(kick), .rdata_o(bus_rdata)
  );

  wdog_expiry #(.CNT_W(CNT_W), .RST_LEN(RST_LEN)) u_exp (
    .clk(clk), .rst_n(rst_n), .run_i(run), .reload_i(reload),
    .state_i(ctl.state), .first_o(first), .second_o(second),
    .irq_o(wdt_irq), .sysrst_o(wdt_reset)
  );

  // R4: reset starts only from the flagged state and records its cause
  assert_reset_after_state_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wdt_reset) |-> $past(ctl.state));
  assert_reset_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wdt_reset) |-> ctl.cause);

  // R5: a service write leaves the state flag clear
  assert_kick_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> !ctl.state);
endmodule

// File: tb/wdog_twostage_tb.sv
module wdog_twostage_tb;
  localparam int N  = 6;
  localparam int P  = 1 << N;
  localparam int RL = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0, wr_o = 1'b0, rd = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, rdata1;
  logic        irq, srst, irq1, srst1;

  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  int n_irq = 0, n_rst = 0, rw = 0;
  logic irq_p = 1'b0, srst_p = 1'b0;

  typedef struct { int kind; int at; } ev_t;
  ev_t evq[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  wdog_twostage #(.CNT_W(N), .RST_LEN(RL), .TB_W(32), .ENABLE_ONCE(0)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(wr), .bus_rd(rd), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .wdt_irq(irq), .wdt_reset(srst));

  wdog_twostage #(.CNT_W(N), .RST_LEN(RL), .TB_W(32), .ENABLE_ONCE(1)) u_dut_once (
    .clk(clk), .rst_n(rst_n), .bus_wr(wr_o), .bus_rd(rd), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata1), .wdt_irq(irq1), .wdt_reset(srst1));

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic push(input int kind, input int at);
    ev_t e;
    e.kind = kind; e.at = at;
    evq.push_back(e);
  endtask

  // monitor: pops expected events as the outputs rise
  always @(negedge clk) begin
    if (rst_n) begin
      if (irq && !irq_p) begin
        n_irq++;
        if (evq.size() > 0 && evq[0].kind == 0) begin
          check(evq[0].at == cyc, "R3 irq cycle", cyc, evq[0].at);
          void'(evq.pop_front());
        end else check(0, "R2 unexpected irq", cyc, -1);
      end
      if (irq && irq_p) check(0, "R3 irq width", 2, 1);
      if (srst && !srst_p) begin
        n_rst++;
        if (evq.size() > 0 && evq[0].kind == 1) begin
          check(evq[0].at == cyc, "R4 reset cycle", cyc, evq[0].at);
          void'(evq.pop_front());
        end else check(0, "R4 unexpected reset", cyc, -1);
      end
      if (srst) rw++;
      if (!srst && srst_p) begin
        check(rw == RL, "R4 reset width", rw, RL);
        rw = 0;
      end
      irq_p  = irq;
      srst_p = srst;
    end
  end

  task automatic wreg(input logic [1:0] a, input logic [31:0] d, output int e);
    wr = 1'b1; addr = a; wdata = d; e = cyc + 1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic wreg_once(input logic [1:0] a, input logic [31:0] d);
    wr_o = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_o = 1'b0;
  endtask

  task automatic rreg(input logic [1:0] a, output logic [31:0] v, output logic [31:0] v1);
    rd = 1'b1; addr = a;
    @(negedge clk);
    rd = 1'b0;
    v = rdata; v1 = rdata1;
  endtask

  task automatic wait_until(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  initial begin
    #(4 * 150000);
    check(0, "watchdog expired", cyc, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] v, v1, t1, t2, t3;
    int e, e0, k1, k2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1: reset state and unused word
    check(irq == 0 && srst == 0, "R1 outputs after reset", {irq, srst}, 0);
    rreg(2'd0, v, v1); check(v == 0, "R1 ctl0 reset", v, 0);
    rreg(2'd1, v, v1); check(v == 0, "R1 ctl1 reset", v, 0);
    rreg(2'd3, v, v1); check(v == 0, "R1 word3 reads 0", v, 0);

    // R7: timebase counts every clock, writes ignored
    rreg(2'd2, t1, v1);
    repeat (4) @(negedge clk);
    rreg(2'd2, t2, v1);
    check(t2 - t1 == 5, "R7 timebase step", t2 - t1, 5);
    wreg(2'd2, 32'd0, e);
    rreg(2'd2, t3, v1);
    check(t3 - t2 == 2, "R7 timebase write ignored", t3 - t2, 2);

    // R1/R2: unused bits, single enable does not run
    wreg(2'd1, 32'hFFFF_FFFE, e);
    rreg(2'd1, v, v1); check(v == 0, "R1 ctl1 unused bits", v, 0);
    wreg(2'd1, 32'hFFFF_FFFF, e);
    rreg(2'd1, v, v1); check(v == 1, "R1 ctl1 enable B", v, 1);
    repeat (3 * P) @(negedge clk);
    check(n_irq == 0, "R2 only enable B", n_irq, 0);
    wreg(2'd1, 32'd0, e);
    wreg(2'd0, 32'h2, e);
    repeat (2 * P) @(negedge clk);
    check(n_irq == 0, "R2 only enable A", n_irq, 0);
    rreg(2'd0, v, v1); check(v == 32'h2, "R1 ctl0 enable A", v, 2);

    // R3/R4: unserviced run
    wreg(2'd1, 32'd1, e0);
    push(0, e0 + P);
    push(1, e0 + 2 * P);
    wait_until(e0 + P + 2);
    rreg(2'd0, v, v1); check(v == 32'h6, "R3 state flag set", v, 6);
    wait_until(e0 + 2 * P + RL + 2);
    rreg(2'd0, v, v1); check(v == 32'hE, "R6 cause survives reset", v, 14);
    wreg(2'd1, 32'd0, e);
    wreg(2'd0, 32'h2, e);
    rreg(2'd0, v, v1); check(v == 32'hE, "R9 zero writes keep flags", v, 14);
    wreg(2'd0, 32'hA, e);
    rreg(2'd0, v, v1); check(v == 32'h6, "R6 cause cleared by write", v, 6);
    wreg(2'd0, 32'h6, e);
    rreg(2'd0, v, v1); check(v == 32'h2, "R5 state cleared by write", v, 2);

    // R5: service restarts the interval
    wreg(2'd1, 32'd1, e);
    repeat (P / 2) @(negedge clk);
    wreg(2'd0, 32'h6, k1);
    push(0, k1 + P);
    wait_until(k1 + P + 3);
    check(n_irq == 2, "R5 irq after early kick", n_irq, 2);
    wreg(2'd0, 32'h6, k2);
    push(0, k2 + P);
    wait_until(k2 + P + 3);
    rreg(2'd0, v, v1); check(v == 32'h6, "R5 serviced no cause", v, 6);
    wreg(2'd0, 32'h4, e);
    rreg(2'd0, v, v1); check(v == 0, "R2 stopped and cleared", v, 0);
    repeat (2 * P) @(negedge clk);
    check(n_rst == 1, "R5 no reset while serviced", n_rst, 1);

    // R8: enable-once lock
    wreg_once(2'd0, 32'h2);
    rreg(2'd0, v, v1); check(v1 == 32'h2, "R8 once enable set", v1, 2);
    wreg_once(2'd0, 32'h0);
    rreg(2'd0, v, v1); check(v1 == 32'h2, "R8 once enable locked", v1, 2);
    check(irq1 == 0 && srst1 == 0, "R2 once instance idle", {irq1, srst1}, 0);

    check(evq.size() == 0, "R3 all expected events seen", evq.size(), 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule